// File: doc/BRIEF.md
# Tagged Multi-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A small untagged table of 2-bit saturating counters, indexed by the low bits of the branch address, provides a default guess. Above it sit four tagged banks. Each bank is indexed by the branch address mixed with a slice of the global outcome history. The slice lengths double from bank to bank (5, 10, 20 and 40 outcomes). The guess comes from the hitting bank with the longest slice. If no bank hits, the untagged table gives the guess.

The caller presents a branch address and reads the guess and the source of that guess in the same cycle. When the real outcome is known, the caller drives it in a cycle where the same address is still presented. The predictor then trains the counter that gave the guess, adjusts usefulness, places a new entry after a wrong guess, and shifts the outcome into the history register. Lookup is purely combinational. All state changes happen at the clock edge of a resolve cycle.

Top module: `tage_predictor`

## Requirements
- R1: After reset every tagged entry is invalid and every base counter holds 1 (weak not-taken), so each address yields pred_taken=0 with pred_provider=0.
- R2: With no tagged hit, pred_provider=0 and pred_taken is bit 1 of the base counter at br_pc[4:0]. On resolve, that counter moves one step toward the outcome, saturating at 0 and 3.
- R3: Bank k (1..4) uses a history length of 5*2^(k-1). When one or more banks hit, pred_provider is the highest hitting k. pred_taken is 1 when that entry's signed 3-bit counter is at least 0.
- R4: On resolve, the providing bank's counter steps toward the outcome, saturating at -4 and +3. Base counters are not trained when a tagged bank provides.
- R5: On a wrong guess, exactly one entry is written: in the lowest bank above the provider whose indexed entry is invalid or has usefulness 0. The new entry is valid, carries the new tag and usefulness 0, and has counter 0 for a taken outcome or -1 for not-taken. No entry is written when the provider is bank 4.
- R6: When a tagged provider's guess differs from the alternate guess (the next lower hitting bank, or base), its 2-bit usefulness rises on a correct guess and falls on a wrong one, saturating. If a wrong guess finds no bank to write, the usefulness of every indexed entry above the provider falls by one.
- R7: Every resolve shifts res_taken into bit 0 of the 40-bit history. Older bits move up by one, and bit 39 drops out.
- R8: Bank index = br_pc[3:0] XOR fold(history[L-1:0],4). Tag = fold(br_pc[15:4],6) XOR fold(history[L-1:0],6). Here fold(x,w) XORs bit i of x into output bit i mod w.
- R9: In cycles with res_valid=0, no table and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_pc | input | 16 | Address of the branch being looked up or resolved |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_provider | output | 3 | Source of the guess: 0 = base table, k = tagged bank k |
| res_valid | input | 1 | The outcome of the branch at br_pc is resolved this cycle |
| res_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A reference model in the bench is built from the requirements alone and compared against the design on every lookup. The lookups cover a biased branch, an alternating branch, a nested loop and a pseudo-random mix of addresses and outcomes.

A directed sequence returns the history to all zeros between visits to one address, which forces a new entry into each bank in turn. A design that writes into the wrong bank, writes into several banks, or seeds the new counter with the wrong value reports the wrong provider or the wrong direction at that point. Writing a bank on a correct guess, or folding history bits into the wrong position, shows up as a provider mismatch in the mixed stream. Idle cycles with moving addresses catch any update that leaks out while no outcome is being resolved.

// File: rtl/tage_pkg.sv
package tage_pkg;
  localparam int CTR_W  = 3;
  localparam int USE_W  = 2;
  localparam int BASE_W = 2;

  typedef logic signed [CTR_W-1:0] ctr_t;
  typedef logic [USE_W-1:0]        use_t;
  typedef logic [BASE_W-1:0]       bctr_t;

  localparam ctr_t CTR_MAX  = ctr_t'({1'b0, {(CTR_W-1){1'b1}}});
  localparam ctr_t CTR_MIN  = ctr_t'({1'b1, {(CTR_W-1){1'b0}}});
  localparam ctr_t CTR_WK_T = ctr_t'(0);
  localparam ctr_t CTR_WK_N = ctr_t'({CTR_W{1'b1}});
  localparam bctr_t BASE_RST = bctr_t'(1);

  // signed direction counter, saturating in both directions
  function automatic ctr_t ctr_train(ctr_t c, logic up);
    ctr_t r;
    r = c;
    if (up && (c != CTR_MAX))
      r = c + ctr_t'(1);
    else if (!up && (c != CTR_MIN))
      r = c - ctr_t'(1);
    return r;
  endfunction

  // usefulness counter, saturating at 0 and all-ones
  function automatic use_t use_step(use_t u, logic inc, logic dec);
    use_t r;
    r = u;
    if (inc && (u != {USE_W{1'b1}}))
      r = u + use_t'(1);
    else if (dec && (u != '0))
      r = u - use_t'(1);
    return r;
  endfunction

  function automatic bctr_t base_train(bctr_t c, logic up);
    bctr_t r;
    r = c;
    if (up && (c != {BASE_W{1'b1}}))
      r = c + bctr_t'(1);
    else if (!up && (c != '0))
      r = c - bctr_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/tage_fold.sv
module tage_fold #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int NCH   = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W = NCH * OUT_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(din);

  always_comb begin
    dout = '0;
    for (int j = 0; j < NCH; j++)
      dout = dout ^ padded[j*OUT_W +: OUT_W];
  end
endmodule

// File: rtl/tage_base.sv
module tage_base
  import tage_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             pred,
  input  logic             trn_en,
  input  logic             taken
);
  localparam int DEPTH = 1 << IDX_W;

  bctr_t tbl_q [DEPTH];
  bctr_t rd;
  bctr_t nxt;

  assign rd   = tbl_q[idx];
  assign pred = rd[BASE_W-1];

  always_comb begin
    nxt = base_train(rd, taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        tbl_q[i] <= BASE_RST;
    end else if (trn_en) begin
      tbl_q[idx] <= nxt;
    end
  end
endmodule

// File: rtl/tage_bank.sv
module tage_bank
  import tage_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 6,
  parameter int HIST_LEN = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    pc_lo,
  input  logic [TAG_W-1:0]    pc_hash,
  input  logic [HIST_LEN-1:0] hist,
  output logic                hit,
  output logic                pred,
  output logic                free,
  input  logic                trn_en,
  input  logic                use_inc,
  input  logic                use_dec,
  input  logic                alloc_en,
  input  logic                taken
);
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    ctr_t             ctr;
    use_t             u;
  } ent_t;

  ent_t             mem_q [DEPTH];
  ent_t             rd;
  ent_t             ent_d;
  logic             wr_en;
  logic [IDX_W-1:0] h_idx;
  logic [TAG_W-1:0] h_tag;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  tage_fold #(.IN_W(HIST_LEN), .OUT_W(IDX_W)) u_fold_idx (.din(hist), .dout(h_idx));
  tage_fold #(.IN_W(HIST_LEN), .OUT_W(TAG_W)) u_fold_tag (.din(hist), .dout(h_tag));

  assign idx  = pc_lo ^ h_idx;
  assign tag  = pc_hash ^ h_tag;
  assign rd   = mem_q[idx];
  assign hit  = rd.vld && (rd.tag == tag);
  assign pred = ~rd.ctr[CTR_W-1];
  assign free = !rd.vld || (rd.u == '0);

  // next-state for the single indexed entry
  always_comb begin
    ent_d = rd;
    wr_en = 1'b0;
    if (alloc_en) begin
      ent_d.vld = 1'b1;
      ent_d.tag = tag;
      ent_d.ctr = taken ? CTR_WK_T : CTR_WK_N;
      ent_d.u   = '0;
      wr_en     = 1'b1;
    end else begin
      if (trn_en)
        ent_d.ctr = ctr_train(rd.ctr, taken);
      if (use_inc || use_dec)
        ent_d.u = use_step(rd.u, use_inc, use_dec);
      wr_en = trn_en || use_inc || use_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= ent_d;
    end
  end
endmodule

// File: rtl/tage_predictor.sv
module tage_predictor
  import tage_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int NUM_TBL    = 4,
  parameter int IDX_W      = 4,
  parameter int TAG_W      = 6,
  parameter int BASE_IDX_W = 5,
  parameter int MIN_HIST   = 5,
  localparam int PROV_W    = $clog2(NUM_TBL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   br_pc,
  output logic              pred_taken,
  output logic [PROV_W-1:0] pred_provider,
  input  logic              res_valid,
  input  logic              res_taken
);
  localparam int GH_W  = MIN_HIST << (NUM_TBL - 1);
  localparam int HI_W  = PC_W - IDX_W;

  logic [GH_W-1:0]    ghist_q;
  logic [GH_W-1:0]    ghist_d;
  logic [TAG_W-1:0]   pc_hash;
  logic               base_pred;
  logic               base_trn;
  logic [NUM_TBL-1:0] hit_vec;
  logic [NUM_TBL-1:0] pred_vec;
  logic [NUM_TBL-1:0] free_vec;
  logic [NUM_TBL-1:0] trn_vec;
  logic [NUM_TBL-1:0] uinc_vec;
  logic [NUM_TBL-1:0] udec_vec;
  logic [NUM_TBL-1:0] alloc_vec;
  logic [PROV_W-1:0]  prov;
  logic               prov_pred;
  logic               alt_pred;
  logic               mispred;
  logic               alloc_found;
  logic               decay_all;

  // upper address bits hashed into the tag width
  tage_fold #(.IN_W(HI_W), .OUT_W(TAG_W)) u_pc_hash (
    .din  (br_pc[PC_W-1:IDX_W]),
    .dout (pc_hash)
  );

  tage_base #(.IDX_W(BASE_IDX_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (br_pc[BASE_IDX_W-1:0]),
    .pred   (base_pred),
    .trn_en (base_trn),
    .taken  (res_taken)
  );

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_bank
    localparam int HL = MIN_HIST << g;
    tage_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_LEN(HL)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pc_lo    (br_pc[IDX_W-1:0]),
      .pc_hash  (pc_hash),
      .hist     (ghist_q[HL-1:0]),
      .hit      (hit_vec[g]),
      .pred     (pred_vec[g]),
      .free     (free_vec[g]),
      .trn_en   (trn_vec[g]),
      .use_inc  (uinc_vec[g]),
      .use_dec  (udec_vec[g]),
      .alloc_en (alloc_vec[g]),
      .taken    (res_taken)
    );
  end

  // provider and alternate: walk banks from shortest to longest history
  always_comb begin
    prov      = '0;
    prov_pred = base_pred;
    alt_pred  = base_pred;
    for (int k = 0; k < NUM_TBL; k++) begin
      if (hit_vec[k]) begin
        prov      = PROV_W'(k + 1);
        alt_pred  = prov_pred;
        prov_pred = pred_vec[k];
      end
    end
  end

  assign pred_taken    = prov_pred;
  assign pred_provider = prov;
  assign mispred       = res_valid && (prov_pred != res_taken);
  assign base_trn      = res_valid && (prov == '0);

  // one new entry in the lowest free bank above the provider
  always_comb begin
    alloc_vec   = '0;
    alloc_found = 1'b0;
    for (int k = 0; k < NUM_TBL; k++) begin
      if (mispred && !alloc_found && (k + 1 > int'(prov)) && free_vec[k]) begin
        alloc_vec[k] = 1'b1;
        alloc_found  = 1'b1;
      end
    end
  end

  assign decay_all = mispred && !alloc_found;

  always_comb begin
    for (int k = 0; k < NUM_TBL; k++) begin
      trn_vec[k]  = res_valid && (int'(prov) == k + 1);
      uinc_vec[k] = trn_vec[k] && (alt_pred != prov_pred) && (prov_pred == res_taken);
      udec_vec[k] = (trn_vec[k] && (alt_pred != prov_pred) && (prov_pred != res_taken)) ||
                    (decay_all && (k + 1 > int'(prov)));
    end
  end

  // global outcome history
  assign ghist_d = {ghist_q[GH_W-2:0], res_taken};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ghist_q <= '0;
    else if (res_valid)
      ghist_q <= ghist_d;
  end
endmodule

// File: rtl/tage_predictor_chk.sv
module tage_predictor_chk #(
  parameter int NUM_TBL = 4,
  parameter int GH_W    = 40,
  parameter int PROV_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               res_valid,
  input logic               res_taken,
  input logic               pred_taken,
  input logic [PROV_W-1:0]  pred_provider,
  input logic [GH_W-1:0]    ghist,
  input logic [NUM_TBL-1:0] hit_vec,
  input logic [NUM_TBL-1:0] alloc_vec
);
  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (ghist == {$past(ghist[GH_W-2:0]), $past(res_taken)}));

  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ghist));

  a_r5_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  a_r5_alloc_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vec != '0) |-> (res_valid && (pred_taken != res_taken)));

  a_r5_alloc_above: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vec != '0) |-> ((alloc_vec & NUM_TBL'((1 << pred_provider) - 1)) == '0));

  a_r3_longest_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_provider != '0) |-> (hit_vec[pred_provider - PROV_W'(1)] && ((hit_vec >> pred_provider) == '0)));

  a_r2_base_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (pred_provider == '0));
endmodule

bind tage_predictor tage_predictor_chk #(
  .NUM_TBL (NUM_TBL),
  .GH_W    (GH_W),
  .PROV_W  (PROV_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .res_valid     (res_valid),
  .res_taken     (res_taken),
  .pred_taken    (pred_taken),
  .pred_provider (pred_provider),
  .ghist         (ghist_q),
  .hit_vec       (hit_vec),
  .alloc_vec     (alloc_vec)
);

// File: tb/tage_predictor_bench.sv
module tage_predictor_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] br_pc;
  logic        pred_taken;
  logic [2:0]  pred_provider;
  logic        res_valid;
  logic        res_taken;

  int n_chk;
  int n_fail;

  tage_predictor u_tage_predictor (
    .clk           (clk),
    .rst_n         (rst_n),
    .br_pc         (br_pc),
    .pred_taken    (pred_taken),
    .pred_provider (pred_provider),
    .res_valid     (res_valid),
    .res_taken     (res_taken)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference state, built from the requirements
  bit [1:0]  m_base [32];
  bit        m_vld  [4][16];
  bit [5:0]  m_tag  [4][16];
  int        m_ctr  [4][16];
  int        m_u    [4][16];
  bit [39:0] m_gh;
  int        mi [4];
  int        mt [4];
  int        m_prov;
  bit        m_pp;
  bit        m_ap;

  function automatic int fold(bit [39:0] h, int len, int w);
    int r;
    r = 0;
    for (int i = 0; i < len; i++)
      if (h[i]) r = r ^ (1 << (i % w));
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_base[i] = 2'd1;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) begin
        m_vld[k][i] = 0; m_tag[k][i] = 0; m_ctr[k][i] = 0; m_u[k][i] = 0;
      end
    m_gh = '0;
  endtask

  task automatic model_look(input bit [15:0] pc);
    bit cur;
    bit alt;
    int ph;
    ph  = fold({28'b0, pc[15:4]}, 12, 6);
    cur = m_base[pc[4:0]][1];
    alt = cur;
    m_prov = 0;
    for (int k = 0; k < 4; k++) begin
      int len;
      len   = 5 << k;
      mi[k] = int'(pc[3:0]) ^ fold(m_gh, len, 4);
      mt[k] = ph ^ fold(m_gh, len, 6);
      if (m_vld[k][mi[k]] && (int'(m_tag[k][mi[k]]) == mt[k])) begin
        m_prov = k + 1;
        alt    = cur;
        cur    = (m_ctr[k][mi[k]] >= 0);
      end
    end
    m_pp = cur;
    m_ap = alt;
  endtask

  task automatic model_update(input bit [15:0] pc, input bit tk);
    bit found;
    if (m_prov == 0) begin
      if (tk && m_base[pc[4:0]] != 2'd3) m_base[pc[4:0]] = m_base[pc[4:0]] + 2'd1;
      if (!tk && m_base[pc[4:0]] != 2'd0) m_base[pc[4:0]] = m_base[pc[4:0]] - 2'd1;
    end else begin
      int k;
      k = m_prov - 1;
      if (tk && m_ctr[k][mi[k]] < 3) m_ctr[k][mi[k]]++;
      if (!tk && m_ctr[k][mi[k]] > -4) m_ctr[k][mi[k]]--;
      if (m_ap != m_pp) begin
        if (m_pp == tk) begin
          if (m_u[k][mi[k]] < 3) m_u[k][mi[k]]++;
        end else begin
          if (m_u[k][mi[k]] > 0) m_u[k][mi[k]]--;
        end
      end
    end
    found = 0;
    if (m_pp != tk) begin
      for (int k = m_prov; k < 4; k++)
        if (!found && (!m_vld[k][mi[k]] || m_u[k][mi[k]] == 0)) begin
          m_vld[k][mi[k]] = 1; m_tag[k][mi[k]] = 6'(mt[k]);
          m_ctr[k][mi[k]] = tk ? 0 : -1; m_u[k][mi[k]] = 0;
          found = 1;
        end
      if (!found)
        for (int k = m_prov; k < 4; k++)
          if (m_u[k][mi[k]] > 0) m_u[k][mi[k]]--;
    end
    m_gh = {m_gh[38:0], tk};
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one lookup (and resolve if vld); compares {provider,direction} with the model
  task automatic step(input bit [15:0] pc, input bit tk, input bit vld, input string ph);
    int act;
    int exp;
    @(negedge clk);
    br_pc = pc; res_valid = vld; res_taken = tk;
    #1;
    model_look(pc);
    act = int'(pred_provider) * 2 + int'(pred_taken);
    exp = m_prov * 2 + int'(m_pp);
    chk(act == exp, (m_prov != 0) ? {ph, "/R3"} : {ph, "/R2"}, act, exp);
    if (vld) model_update(pc, tk);
  endtask

  task automatic fill_zero(input int n);
    for (int i = 0; i < n; i++) step(16'h0120, 1'b0, 1'b1, "R5");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [31:0] r;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; br_pc = '0; res_valid = 1'b0; res_taken = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every base entry weak not-taken, no tagged hits
    for (int i = 0; i < 32; i++) begin
      step(16'(i), 1'b0, 1'b0, "R1");
      chk(pred_taken == 1'b0 && pred_provider == 3'd0, "R1", int'(pred_provider) * 2 + int'(pred_taken), 0);
    end

    // R5: history returns to zero between visits of 0x0013, one bank gains an entry per miss
    step(16'h0013, 1'b1, 1'b1, "R5");
    fill_zero(40);
    step(16'h0013, 1'b0, 1'b0, "R5");
    chk(pred_provider == 3'd1 && pred_taken, "R5", int'(pred_provider) * 2 + int'(pred_taken), 3);
    step(16'h0013, 1'b0, 1'b1, "R5");
    fill_zero(40);
    step(16'h0013, 1'b0, 1'b0, "R5");
    chk(pred_provider == 3'd2 && !pred_taken, "R5", int'(pred_provider) * 2 + int'(pred_taken), 4);
    step(16'h0013, 1'b1, 1'b1, "R5");
    fill_zero(40);
    step(16'h0013, 1'b0, 1'b0, "R5");
    chk(pred_provider == 3'd3 && pred_taken, "R5", int'(pred_provider) * 2 + int'(pred_taken), 7);
    step(16'h0013, 1'b0, 1'b1, "R5");
    fill_zero(40);
    step(16'h0013, 1'b0, 1'b0, "R5");
    chk(pred_provider == 3'd4 && !pred_taken, "R5", int'(pred_provider) * 2 + int'(pred_taken), 8);
    // R4: provider counter -1 -> 0 after a taken outcome
    step(16'h0013, 1'b1, 1'b1, "R4");
    fill_zero(40);
    step(16'h0013, 1'b0, 1'b0, "R4");
    chk(pred_provider == 3'd4 && pred_taken, "R4", int'(pred_provider) * 2 + int'(pred_taken), 9);

    // R4: biased branch, then reversal
    for (int i = 0; i < 20; i++) step(16'h0055, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 20; i++) step(16'h0055, 1'b0, 1'b1, "R4");

    // R7: alternating branch depends on history
    for (int i = 0; i < 200; i++) step(16'h0200, i[0], 1'b1, "R7");

    // R6: nested loop, inner exits every seventh pass
    for (int i = 0; i < 120; i++) begin
      for (int j = 0; j < 7; j++) step(16'h0a31, (j != 6), 1'b1, "R6");
      step(16'h0b42, i[1], 1'b1, "R6");
    end

    // R8: pseudo-random mix of addresses and outcomes
    r = 32'h1234_5678;
    for (int i = 0; i < 2000; i++) begin
      bit [15:0] pc;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      pc = {r[15:13], 3'b0, r[12:10], 7'b0, r[2:0]};
      step(pc, r[20] ^ (r[21] & r[22]) ^ pc[15], 1'b1, "R8");
    end

    // R9: idle cycles with moving addresses change nothing
    for (int i = 0; i < 40; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      step(r[15:0], r[16], 1'b0, "R9");
    end
    for (int i = 0; i < 20; i++) step(16'h0a31, 1'b1, 1'b1, "R9");

    @(negedge clk) res_valid = 1'b0;
    finish_run();
  end
endmodule